// File: doc/BRIEF.md
# Interrupt Entry Arbiter for an 8-bit CPU Sequencer

This block sits next to the cycle sequencer of a small 8-bit processor and decides, in the opcode-fetch cycle, whether the sequencer should run a normal fetch or start an interrupt entry. It watches a reset request, a non-maskable request, two maskable request lines and the processor's interrupt-disable flag. The sequencer supplies a free-running cycle count and a strobe that marks the fetch cycle. In that same cycle the arbiter returns the start state for the sequencer, the vector address to read, and one-cycle pulses that acknowledge a non-maskable entry or a reset entry.

A request is taken only after it has been visible for a minimum number of cycles, measured as the difference of the cycle count against a timestamp captured when the request rose. The subtraction wraps modulo the counter width. The non-maskable input is edge-detected and latched until it is accepted. The maskable pair is ORed and treated as a level. When the bus-available input is low the cycle is a stall, and the arbiter makes no decision and keeps all of its pending state.

Top module: `irq_entry_arbiter`

## Requirements
- R1: With the fetch strobe low or the bus-available input low, seq_load, nmi_clr and reset_pulse are all 0, and start_state and vector read 16'h0000.
- R2: When fetch and bus-available are high and rst_req is high, the arbiter outputs seq_load=1, reset_pulse=1, start_state=16'h0000 and vector=16'hFFFC, whatever other requests are pending.
- R3: Below reset, an eligible non-maskable request wins over an eligible maskable one. It gives seq_load=1, nmi_clr=1, start_state=16'h0010 and vector=16'hFFFA. The maskable request is taken at a later fetch.
- R4: A non-maskable request that rises in cycle k is eligible at a fetch in cycle k+2 or later, and is not eligible in cycle k or k+1. Age is the cycle count minus the count captured at the rise.
- R5: After a non-maskable entry is accepted, its pending bit is cleared. Keeping nmi_req high causes no further entry. A fresh low-to-high transition is needed.
- R6: The maskable request is irq_a OR irq_b. It is taken only with i_flag low, and gives seq_load=1, start_state=16'h0008 and vector=16'hFFFE, with nmi_clr and reset_pulse low.
- R7: A maskable request whose combined line rises in cycle k is eligible from cycle k+2 on.
- R8: The maskable request is a level. While the line stays high and i_flag stays low, it is taken again at every later fetch.
- R9: A reset entry clears the pending non-maskable bit and the stored line levels. A non-maskable line still held high after the reset counts as a new rise in the following cycle, and is taken two cycles after that.
- R10: The age is computed modulo 2^16, so a request that rises at count 16'hFFFF is eligible when the count reads 16'h0001.
- R11: A fetch with bus-available low keeps a pending non-maskable request, and it is taken at the next fetch with bus-available high.
- R12: The synchronous block reset rst clears all pending and level state, and the outputs read as idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| fetch_stb | input | 1 | High when the sequencer is in the opcode-fetch cycle |
| bus_avail | input | 1 | Low when the current cycle is a stalled read |
| rst_req | input | 1 | Processor reset request |
| nmi_req | input | 1 | Non-maskable request line |
| irq_a | input | 1 | Maskable request source A |
| irq_b | input | 1 | Maskable request source B |
| i_flag | input | 1 | Interrupt-disable flag, 1 masks irq_a/irq_b |
| cycle_cnt | input | 16 | Free-running cycle count |
| seq_load | output | 1 | Load start_state into the sequencer this cycle |
| start_state | output | 16 | Sequencer start state: opcode in the upper byte, cycle index in the lower byte |
| vector | output | 16 | Vector address for the accepted entry |
| nmi_clr | output | 1 | Pulse: non-maskable entry accepted |
| reset_pulse | output | 1 | Pulse: reset entry accepted |

## Verification
The bench builds the block with its default parameters: a 16-bit count and a minimum age of 2. With these values the two-cycle holdoff for each request can be checked cycle by cycle. Because the counter is only 16 bits, the bench can load it with 16'hFFFF and check acceptance across the wrap. The chosen age also leaves a short window in which a reset, a stall or the mask flag can be applied between the rise of a request and its acceptance.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
    parameter int CNT_W   = 16;
    parameter int STATE_W = 16;
    parameter int VEC_W   = 16;

    localparam logic [STATE_W-1:0] ST_FETCH = 16'h0000;
    localparam logic [STATE_W-1:0] ST_IRQ   = 16'h0008;
    localparam logic [STATE_W-1:0] ST_NMI   = 16'h0010;

    localparam logic [VEC_W-1:0] VEC_NMI   = 16'hFFFA;
    localparam logic [VEC_W-1:0] VEC_RESET = 16'hFFFC;
    localparam logic [VEC_W-1:0] VEC_IRQ   = 16'hFFFE;

    typedef enum logic [1:0] {
        ENT_NONE,
        ENT_RESET,
        ENT_NMI,
        ENT_IRQ
    } entry_kind_e;

    typedef struct packed {
        entry_kind_e         kind;
        logic [STATE_W-1:0]  start_state;
        logic [VEC_W-1:0]    vector;
    } entry_t;

    function automatic entry_t make_entry(entry_kind_e k);
        entry_t e;
        e.kind = k;
        case (k)
            ENT_RESET: begin e.start_state = ST_FETCH; e.vector = VEC_RESET; end
            ENT_NMI:   begin e.start_state = ST_NMI;   e.vector = VEC_NMI;   end
            ENT_IRQ:   begin e.start_state = ST_IRQ;   e.vector = VEC_IRQ;   end
            default:   begin e.start_state = '0;       e.vector = '0;        end
        endcase
        return e;
    endfunction
endpackage

// File: rtl/req_tracker.sv
module req_tracker #(
    parameter int CNT_W   = irq_entry_pkg::CNT_W,
    parameter int MIN_AGE = 2,
    parameter bit LATCHED = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [CNT_W-1:0] cnt,
    input  logic             ack,
    input  logic             flush,
    output logic             eligible
);
    localparam logic [CNT_W-1:0] AGE_MIN = CNT_W'(MIN_AGE);

    logic             level_q;
    logic [CNT_W-1:0] stamp_q;
    logic             pending;
    logic             rise;
    logic [CNT_W-1:0] age;

    assign rise = req & ~level_q;
    assign age  = cnt - stamp_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            level_q <= 1'b0;
            stamp_q <= '0;
        end else begin
            level_q <= req;
            if (rise && (!pending || ack))
                stamp_q <= cnt;
        end
    end

    generate
        if (LATCHED) begin : g_edge
            logic pend_q;
            always_ff @(posedge clk) begin
                if (rst || flush)
                    pend_q <= 1'b0;
                else
                    pend_q <= rise | (pend_q & ~ack);
            end
            assign pending = pend_q;
        end else begin : g_level
            assign pending = req & level_q;
        end
    endgenerate

    assign eligible = pending && (age >= AGE_MIN);
endmodule

// File: rtl/entry_priority.sv
module entry_priority
    import irq_entry_pkg::*;
(
    input  logic   decide,
    input  logic   rst_req,
    input  logic   nmi_ok,
    input  logic   irq_ok,
    input  logic   i_flag,
    output entry_t entry
);
    always_comb begin
        if (!decide)
            entry = make_entry(ENT_NONE);
        else if (rst_req)
            entry = make_entry(ENT_RESET);
        else if (nmi_ok)
            entry = make_entry(ENT_NMI);
        else if (irq_ok && !i_flag)
            entry = make_entry(ENT_IRQ);
        else
            entry = make_entry(ENT_NONE);
    end
endmodule

// File: rtl/irq_entry_arbiter.sv
module irq_entry_arbiter
    import irq_entry_pkg::*;
#(
    parameter int MIN_AGE = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fetch_stb,
    input  logic               bus_avail,
    input  logic               rst_req,
    input  logic               nmi_req,
    input  logic               irq_a,
    input  logic               irq_b,
    input  logic               i_flag,
    input  logic [CNT_W-1:0]   cycle_cnt,
    output logic               seq_load,
    output logic [STATE_W-1:0] start_state,
    output logic [VEC_W-1:0]   vector,
    output logic               nmi_clr,
    output logic               reset_pulse
);
    entry_t dec;
    logic   nmi_ok, irq_ok;
    logic   nmi_ack, flush;

    assign nmi_ack = (dec.kind == ENT_NMI);
    assign flush   = (dec.kind == ENT_RESET);

    req_tracker #(.CNT_W(CNT_W), .MIN_AGE(MIN_AGE), .LATCHED(1'b1)) u_nmi (
        .clk(clk), .rst(rst), .req(nmi_req), .cnt(cycle_cnt),
        .ack(nmi_ack), .flush(flush), .eligible(nmi_ok)
    );

    req_tracker #(.CNT_W(CNT_W), .MIN_AGE(MIN_AGE), .LATCHED(1'b0)) u_irq (
        .clk(clk), .rst(rst), .req(irq_a | irq_b), .cnt(cycle_cnt),
        .ack(1'b0), .flush(flush), .eligible(irq_ok)
    );

    entry_priority u_prio (
        .decide (fetch_stb & bus_avail),
        .rst_req(rst_req),
        .nmi_ok (nmi_ok),
        .irq_ok (irq_ok),
        .i_flag (i_flag),
        .entry  (dec)
    );

    assign seq_load    = (dec.kind != ENT_NONE);
    assign start_state = dec.start_state;
    assign vector      = dec.vector;
    assign nmi_clr     = nmi_ack;
    assign reset_pulse = flush;
endmodule

// File: rtl/irq_entry_arbiter_chk.sv
module irq_entry_arbiter_chk (
    input logic        clk,
    input logic        rst,
    input logic        fetch_stb,
    input logic        bus_avail,
    input logic        rst_req,
    input logic        irq_a,
    input logic        irq_b,
    input logic        i_flag,
    input logic        seq_load,
    input logic [15:0] start_state,
    input logic [15:0] vector,
    input logic        nmi_clr,
    input logic        reset_pulse
);
    logic irq_take;
    assign irq_take = seq_load && !nmi_clr && !reset_pulse;

    assert_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !(fetch_stb && bus_avail) |-> (!seq_load && !nmi_clr && !reset_pulse));

    assert_reset_vec_R2: assert property (@(posedge clk) disable iff (rst)
        reset_pulse |-> (rst_req && vector == 16'hFFFC && start_state == 16'h0000 && !nmi_clr));

    assert_nmi_vec_R3: assert property (@(posedge clk) disable iff (rst)
        nmi_clr |-> (!rst_req && seq_load && vector == 16'hFFFA && start_state == 16'h0010));

    assert_one_kind_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reset_pulse, nmi_clr, irq_take}));

    assert_nmi_single_R5: assert property (@(posedge clk) disable iff (rst)
        nmi_clr |=> !nmi_clr);

    assert_irq_mask_R6: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> (!i_flag && (irq_a || irq_b) && vector == 16'hFFFE && start_state == 16'h0008));
endmodule

bind irq_entry_arbiter irq_entry_arbiter_chk u_chk (.*);

// File: tb/irq_entry_arbiter_tb.sv
module irq_entry_arbiter_tb;
    typedef struct {
        string       tag;
        bit          load;
        logic [15:0] st;
        logic [15:0] vec;
        bit          clr;
        bit          rp;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_stb = 1'b0, bus_avail = 1'b1, rst_req = 1'b0;
    logic        nmi_req = 1'b0, irq_a = 1'b0, irq_b = 1'b0, i_flag = 1'b0;
    logic [15:0] cycle_cnt = 16'h0100;
    logic        seq_load, nmi_clr, reset_pulse;
    logic [15:0] start_state, vector;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cycle_cnt <= cycle_cnt + 16'd1;

    irq_entry_arbiter u_dut (.*);

    // monitor: compares shortly before the rising edge
    always @(negedge clk) begin
        #3;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (seq_load !== e.load || start_state !== e.st || vector !== e.vec ||
                nmi_clr !== e.clr || reset_pulse !== e.rp) begin
                errors++;
                $display("FAIL %s: got load=%0b st=%h vec=%h clr=%0b rp=%0b, expected load=%0b st=%h vec=%h clr=%0b rp=%0b",
                         e.tag, seq_load, start_state, vector, nmi_clr, reset_pulse,
                         e.load, e.st, e.vec, e.clr, e.rp);
            end
        end
    end

    task automatic push(string tag, bit ld, logic [15:0] st, logic [15:0] vec, bit clr, bit rp);
        exp_t e;
        e.tag = tag; e.load = ld; e.st = st; e.vec = vec; e.clr = clr; e.rp = rp;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle();            @(negedge clk); endtask
    task automatic quiet(string t);   push(t, 0, 16'h0000, 16'h0000, 0, 0); endtask
    task automatic is_irq(string t);  push(t, 1, 16'h0008, 16'hFFFE, 0, 0); endtask
    task automatic is_nmi(string t);  push(t, 1, 16'h0010, 16'hFFFA, 1, 0); endtask
    task automatic is_rst(string t);  push(t, 1, 16'h0000, 16'hFFFC, 0, 1); endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk); idle(); idle();
        rst = 1'b0;
        fetch_stb = 1'b1;
        quiet("R12 idle after block reset");

        // maskable from source A
        irq_a = 1'b1;
        quiet("R7 irq rise cycle");
        quiet("R7 irq age 1");
        is_irq("R6 R7 irq at age 2");
        is_irq("R8 irq level retaken");
        i_flag = 1'b1;
        quiet("R6 irq masked by i_flag");
        irq_a = 1'b0; i_flag = 1'b0;
        idle();

        // maskable from source B, fetch low meanwhile
        irq_b = 1'b1; fetch_stb = 1'b0;
        quiet("R1 fetch low irq_b rise");
        quiet("R1 fetch low irq_b age 1");
        quiet("R1 fetch low irq_b age 2");
        fetch_stb = 1'b1;
        is_irq("R6 irq_b via OR");
        irq_b = 1'b0;
        idle();

        // non-maskable timing and edge behaviour
        nmi_req = 1'b1;
        quiet("R4 nmi rise cycle");
        quiet("R4 nmi age 1");
        is_nmi("R4 nmi at age 2");
        quiet("R5 nmi held no retake");
        quiet("R5 nmi held no retake 2");
        nmi_req = 1'b0; fetch_stb = 1'b0;
        idle();
        nmi_req = 1'b1;
        idle(); idle();
        fetch_stb = 1'b1;
        is_nmi("R5 new edge taken");
        nmi_req = 1'b0;
        idle();

        // priority nmi over irq
        fetch_stb = 1'b0; nmi_req = 1'b1; irq_a = 1'b1;
        idle(); idle();
        fetch_stb = 1'b1;
        is_nmi("R3 nmi beats irq");
        is_irq("R3 irq after nmi");
        nmi_req = 1'b0; irq_a = 1'b0;
        idle();

        // reset beats all, clears nmi state
        fetch_stb = 1'b0; nmi_req = 1'b1; irq_a = 1'b1;
        idle(); idle();
        fetch_stb = 1'b1; rst_req = 1'b1;
        is_rst("R2 reset beats nmi and irq");
        rst_req = 1'b0; irq_a = 1'b0;
        quiet("R9 nmi pending cleared by reset");
        quiet("R9 held nmi age 1 after reset");
        is_nmi("R9 held nmi seen as new rise");
        nmi_req = 1'b0;
        idle();

        // stall holds pending nmi
        fetch_stb = 1'b0; nmi_req = 1'b1;
        idle(); idle();
        fetch_stb = 1'b1; bus_avail = 1'b0;
        quiet("R11 R1 stall no decision");
        quiet("R11 stall no decision 2");
        bus_avail = 1'b1;
        is_nmi("R11 nmi taken after stall");
        nmi_req = 1'b0;
        idle();

        // counter wrap
        cycle_cnt = 16'hFFFF; nmi_req = 1'b1;
        quiet("R10 rise at FFFF");
        quiet("R10 count 0000 age 1");
        is_nmi("R10 count 0001 age 2");
        nmi_req = 1'b0;
        idle();

        // block reset clears pending
        fetch_stb = 1'b0; nmi_req = 1'b1;
        idle(); idle();
        rst = 1'b1;
        idle();
        rst = 1'b0; fetch_stb = 1'b1;
        quiet("R12 pending nmi cleared by rst");
        quiet("R12 held nmi age 1 after rst");
        is_nmi("R12 held nmi retaken after rst");
        nmi_req = 1'b0;
        idle(); idle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule